// File: doc/BRIEF.md
# Horizontal Blanking and Clock Masking Unit

This unit builds a horizontal blanking window with up to three separate intervals per line. While that window is active, it holds four horizontal CCD clock phases at fixed levels. A pixel counter restarts on every horizontal sync pulse. The counter is compared against six programmable toggle positions, taken as three start/end pairs. The positions come from one of four stored sequences, and the sequence used for a line is chosen at that line's sync pulse.

Each sequence also stores a mask polarity bit, which picks the levels the clock phases take during blanking. Outside blanking, the free-running phases pass straight through. Both the blanking output and the gated phases come from registers, so they change together on the same pixel clock edge. Software writes the sequence table through a simple write port that takes an index and data.

Top module: `hblank_mask_unit`

## Requirements
- R1: While `rst` is high and after it falls, `blank_out` is 0 and `hclk_out` is 4'b0000. Every stored toggle position and mask bit clears to 0, so no interval is enabled.
- R2: The clock edge that samples `hsync` high sets the pixel counter to 0 and drives `blank_out` to 0. Call that edge E0. After edge E(p+1), the outputs show pixel p.
- R3: Blanking has no start polarity. Pixel p is blanked when p ≥ start and p < end for some pair, and this holds even when start is 0.
- R4: Positions 1/2 bound interval one, positions 3/4 bound interval two, and positions 5/6 bound interval three. Several intervals can occur within one line.
- R5: A pair whose two positions are equal never blanks any pixel.
- R6: With the mask bit at 1, `hclk_out` is 4'b1010 during blanking. Bit 0 is phase 1, so phases 1 and 3 are low and phases 2 and 4 are high.
- R7: With the mask bit at 0, `hclk_out` is 4'b0101 during blanking.
- R8: Outside blanking, `hclk_out` equals the `hclk_in` that was sampled at the same edge. The forced levels switch on the same edge on which `blank_out` rises.
- R9: `seq_sel` is captured only on the edge that samples `hsync`. A change in the middle of a line has no effect until the next sync.
- R10: Write encoding: on a clock edge with `wr_en` at 1, `wr_idx` 0 to 5 stores `wr_data` as toggle position 1 to 6 of sequence `wr_seq`. `wr_idx` 6 stores `wr_data[0]` as the mask bit. `wr_idx` 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Line start pulse |
| seq_sel | input | 2 | Sequence chosen for the next line |
| wr_en | input | 1 | Table write strobe |
| wr_seq | input | 2 | Sequence being written |
| wr_idx | input | 3 | Field index (0-5 toggles, 6 mask) |
| wr_data | input | 12 | Position or mask data |
| hclk_in | input | 4 | Free-running clock phases, bit 0 = phase 1 |
| blank_out | output | 1 | Horizontal blanking, active high |
| hclk_out | output | 4 | Gated clock phases |

## Verification
A pixel counter that is off by one moves every interval edge by one pixel. That error appears on `blank_out` at the first programmed boundary of the line. A wrong latched sequence or a wrong mask bit shows up in the first blanked pixel, as a shifted window or an inverted forced pattern on `hclk_out`. A corrupt table write shows up only in the next line that uses the affected sequence, so every sequence is written and then exercised over a full line.

// File: rtl/hblank_pkg.sv
package hblank_pkg;
  parameter int POS_W   = 12;
  parameter int NUM_TOG = 6;
  localparam int NUM_PAIR = NUM_TOG / 2;
  localparam int IDX_W    = $clog2(NUM_TOG + 1);

  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    logic                    mask;
    logic [NUM_TOG-1:0][POS_W-1:0] tog;
  } seq_cfg_t;
endpackage

// File: rtl/hblank_seq_regs.sv
module hblank_seq_regs
  import hblank_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int SEL_W   = $clog2(NUM_SEQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_seq,
  input  logic [IDX_W-1:0] wr_idx,
  input  pos_t             wr_data,
  input  logic [SEL_W-1:0] rd_seq,
  output seq_cfg_t         rd_cfg
);
  seq_cfg_t cfg_q [NUM_SEQ];

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[s] <= '0;
      end else if (wr_en && wr_seq == SEL_W'(s)) begin
        if (wr_idx < IDX_W'(NUM_TOG))
          cfg_q[s].tog[wr_idx] <= wr_data;
        else if (wr_idx == IDX_W'(NUM_TOG))
          cfg_q[s].mask <= wr_data[0];
      end
    end
  end

  assign rd_cfg = cfg_q[rd_seq];
endmodule

// File: rtl/hblank_window.sv
module hblank_window
  import hblank_pkg::*;
(
  input  pos_t                          pix,
  input  logic [NUM_TOG-1:0][POS_W-1:0] tog,
  output logic                          hit
);
  logic [NUM_PAIR-1:0] pair_hit;

  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    assign pair_hit[k] = (pix >= tog[2*k]) && (pix < tog[2*k+1]);
  end

  assign hit = |pair_hit;
endmodule

// File: rtl/hblank_clk_gate.sv
module hblank_clk_gate #(
  parameter int NPH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           blank_d,
  input  logic           mask,
  input  logic [NPH-1:0] ph_in,
  output logic           blank_q,
  output logic [NPH-1:0] ph_out
);
  logic [NPH-1:0] forced;

  // odd-numbered phases (even bit index) take the inverse of mask
  for (genvar i = 0; i < NPH; i++) begin : g_force
    if (i % 2 == 0) begin : g_odd_phase
      assign forced[i] = ~mask;
    end else begin : g_even_phase
      assign forced[i] = mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_q <= 1'b0;
      ph_out  <= '0;
    end else begin
      blank_q <= blank_d;
      ph_out  <= blank_d ? forced : ph_in;
    end
  end
endmodule

// File: rtl/hblank_mask_unit.sv
module hblank_mask_unit
  import hblank_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int NPH     = 4,
  localparam int SEL_W  = $clog2(NUM_SEQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync,
  input  logic [SEL_W-1:0] seq_sel,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_seq,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [POS_W-1:0] wr_data,
  input  logic [NPH-1:0]   hclk_in,
  output logic             blank_out,
  output logic [NPH-1:0]   hclk_out
);
  pos_t             cnt;
  logic [SEL_W-1:0] act_seq;
  seq_cfg_t         act_cfg;
  logic             act_mask;
  logic             win_hit;

  // pixel counter restarts at sync and holds at its ceiling
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_seq <= '0;
    end else if (hsync) begin
      cnt     <= '0;
      act_seq <= seq_sel;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  hblank_seq_regs #(.NUM_SEQ(NUM_SEQ), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_seq(wr_seq), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_seq(act_seq), .rd_cfg(act_cfg)
  );

  assign act_mask = act_cfg.mask;

  hblank_window u_win (
    .pix(cnt), .tog(act_cfg.tog), .hit(win_hit)
  );

  hblank_clk_gate #(.NPH(NPH)) u_gate (
    .clk(clk), .rst(rst), .blank_d(win_hit & ~hsync), .mask(act_mask),
    .ph_in(hclk_in), .blank_q(blank_out), .ph_out(hclk_out)
  );
endmodule

// File: rtl/hblank_mask_unit_chk.sv
module hblank_mask_unit_chk #(
  parameter int SEL_W = 2,
  parameter int POS_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             hsync,
  input logic [SEL_W-1:0] seq_sel,
  input logic [3:0]       hclk_in,
  input logic             blank_out,
  input logic [3:0]       hclk_out,
  input logic [SEL_W-1:0] act_seq,
  input logic             act_mask,
  input logic [POS_W-1:0] cnt
);
  assert_line_start_R2: assert property (@(posedge clk) disable iff (rst)
    $past(hsync) |-> !blank_out);

  assert_count_clear_R2: assert property (@(posedge clk) disable iff (rst)
    $past(hsync) |-> cnt == '0);

  assert_mask_high_R6: assert property (@(posedge clk) disable iff (rst)
    (blank_out && $past(act_mask)) |-> hclk_out == 4'b1010);

  assert_mask_low_R7: assert property (@(posedge clk) disable iff (rst)
    (blank_out && !$past(act_mask)) |-> hclk_out == 4'b0101);

  assert_pass_through_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !blank_out) |-> hclk_out == $past(hclk_in));

  assert_sel_capture_R9: assert property (@(posedge clk) disable iff (rst)
    $past(hsync) |-> act_seq == $past(seq_sel));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(hsync) && !$past(rst)) |-> $stable(act_seq));
endmodule

bind hblank_mask_unit hblank_mask_unit_chk #(.SEL_W(SEL_W), .POS_W(hblank_pkg::POS_W)) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .seq_sel(seq_sel), .hclk_in(hclk_in),
  .blank_out(blank_out), .hclk_out(hclk_out), .act_seq(act_seq),
  .act_mask(act_mask), .cnt(cnt)
);

// File: tb/hblank_mask_unit_test.sv
module hblank_mask_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync = 1'b0;
  logic [1:0]  seq_sel = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_seq = '0;
  logic [2:0]  wr_idx = '0;
  logic [11:0] wr_data = '0;
  logic [3:0]  hclk_in = '0;
  logic        blank_out;
  logic [3:0]  hclk_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic       blank;
    logic [3:0] ph;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  int tog_m [4][6];
  bit mask_m [4];

  always #4 clk = ~clk;  // 125 MHz

  hblank_mask_unit uut (
    .clk(clk), .rst(rst), .hsync(hsync), .seq_sel(seq_sel), .wr_en(wr_en),
    .wr_seq(wr_seq), .wr_idx(wr_idx), .wr_data(wr_data), .hclk_in(hclk_in),
    .blank_out(blank_out), .hclk_out(hclk_out)
  );

  // monitor: results appear 1 ns after the edge following the push
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (blank_out !== e.blank || hclk_out !== e.ph) begin
        n_fails++;
        $display("FAIL %s: blank/hclk actual %0b/%4b expected %0b/%4b",
                 e.req, blank_out, hclk_out, e.blank, e.ph);
      end
    end
  end

  task automatic write_reg(input int s, input int idx, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_seq = 2'(s); wr_idx = 3'(idx); wr_data = 12'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < 6) tog_m[s][idx] = data;
    else if (idx == 6) mask_m[s] = data[0];  // R10: index 7 is ignored
  endtask

  task automatic load_seq(input int s, input int t[6], input bit m);
    for (int i = 0; i < 6; i++) write_reg(s, i, t[i]);
    write_reg(s, 6, int'(m));
  endtask

  function automatic bit model_blank(input int s, input int p);
    for (int k = 0; k < 3; k++)
      if (p >= tog_m[s][2*k] && p < tog_m[s][2*k+1]) return 1'b1;
    return 1'b0;
  endfunction

  // drive one line; mid_sel != -1 changes seq_sel at pixel 5 (R9)
  task automatic run_line(input int s, input int len, input string tag, input int mid_sel);
    exp_t e;
    @(negedge clk);
    hsync = 1'b1; seq_sel = 2'(s); hclk_in = 4'hC;
    e.blank = 1'b0; e.ph = hclk_in; e.req = "R2";
    exp_q.push_back(e);
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      hsync = 1'b0;
      if (p == 5 && mid_sel >= 0) seq_sel = 2'(mid_sel);
      hclk_in = 4'(p * 5 + 3);
      e.blank = model_blank(s, p);
      if (e.blank) begin
        e.ph  = mask_m[s] ? 4'b1010 : 4'b0101;
        e.req = mask_m[s] ? "R6" : "R7";
      end else begin
        e.ph  = hclk_in;
        e.req = {tag, "/R8"};
      end
      exp_q.push_back(e);
    end
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      mask_m[s] = 1'b0;
      for (int i = 0; i < 6; i++) tog_m[s][i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    n_checks++;
    if (blank_out !== 1'b0 || hclk_out !== 4'b0000) begin
      n_fails++;
      $display("FAIL R1: blank/hclk actual %0b/%4b expected 0/0000", blank_out, hclk_out);
    end
    rst = 1'b0;
    hclk_in = 4'hF;
    // R1: cleared table means no blanking in a line
    run_line(0, 12, "R1", -1);

    load_seq(0, '{3, 7, 10, 12, 20, 26}, 1'b1);  // R4 three intervals
    load_seq(1, '{5, 9, 15, 15, 30, 33}, 1'b0);  // R5 middle pair disabled
    load_seq(2, '{0, 4, 4, 4, 4, 4}, 1'b1);      // R3 start at pixel 0
    load_seq(3, '{2, 6, 8, 8, 11, 11}, 1'b0);    // R5 single interval

    run_line(0, 40, "R4", -1);
    run_line(1, 40, "R9", 0);
    run_line(2, 12, "R3", -1);
    run_line(3, 16, "R5", -1);
    // R10: index 7 writes must not disturb sequence 0
    write_reg(0, 7, 12'hFFF);
    write_reg(0, 7, 0);
    run_line(0, 40, "R10", -1);
    // R10: rewrite a position and the mask, then reuse
    write_reg(0, 0, 1);
    write_reg(0, 6, 0);
    run_line(0, 30, "R10", -1);

    @(negedge clk);
    hsync = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule